// File: doc/BRIEF.md
# Storage Address Validity Checker

This block decides whether a storage access falls inside the installed storage. It also decides how the instruction must end when it does not. Each request carries the following:

- a 24-bit start address;
- a length of 1 to 16 bytes;
- a flag that marks an instruction fetch;
- a flag that marks an operand whose storing is the only result of its instruction;
- a flag for the opcode class that always suppresses.

The installed storage is given as a page-capacity count. The block checks every byte of the access against that count. It reports whether the access is invalid. For an invalid access it reports whether the exception suppresses the instruction or terminates it. For a store it also gives a per-byte write enable, so the valid part of a partly invalid store can still be written.

An access holds at most 16 bytes, so it touches at most two consecutive pages. The block therefore needs only two page comparisons per request. A lane map then tells, for each byte, which of the two pages the byte lies in. The result is registered. It appears one clock after the request strobe and is zero in every other cycle.

Top module: `saddr_chk`

## Requirements
- R1: A request sampled with `req_vld` high at a rising edge gives its result on `rsp_vld`, `rsp_invalid`, `rsp_suppress` and `rsp_byte_we` right after that edge. In a cycle that follows an edge without a request, all four outputs are zero.
- R2: The page number of a byte is address bits [23:11] (2 KiB pages). A byte is invalid when its page number is equal to or greater than the 14-bit `page_cap`. A count of 8192 makes every page valid, and a count of 0 makes every page invalid.
- R3: An access covers `req_len_m1`+1 consecutive bytes. Addresses wrap modulo 2^24. `rsp_invalid` is 1 when any covered byte is invalid.
- R4: When `req_ifetch` is 1 and any byte of the instruction is invalid, the result is suppression (`rsp_suppress`=1) and `rsp_byte_we` is 0. An instruction is invalid when any of its halfwords is at an invalid address.
- R5: An invalid operand access that no other rule covers terminates (`rsp_invalid`=1, `rsp_suppress`=0).
- R6: When `req_always_supp` is 1, an invalid operand suppresses and `rsp_byte_we` is 0. A valid access under this flag gives no exception.
- R7: When `req_store_only` is 1 and every covered byte is invalid, the result is suppression with `rsp_byte_we` = 0.
- R8: A store-only operand that is not suppressed gets `rsp_byte_we` bit i = 1 exactly for each covered byte i (0 = lowest address) that is valid. For a fully valid store, bits 0..len_m1 are set.
- R9: An operand with `req_store_only` = 0 always yields `rsp_byte_we` = 0. A valid access always yields `rsp_invalid` = 0 and `rsp_suppress` = 0.
- R10: While reset is applied, and until the first request after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | Request strobe |
| req_addr | input | 24 | Start address of the access |
| req_len_m1 | input | 4 | Access length in bytes minus one |
| req_ifetch | input | 1 | 1 = instruction fetch, 0 = operand |
| req_store_only | input | 1 | Operand is a store and is the instruction's only result |
| req_always_supp | input | 1 | Opcode belongs to the always-suppressing class |
| page_cap | input | 14 | Page-capacity count |
| rsp_vld | output | 1 | Result valid |
| rsp_invalid | output | 1 | Addressing exception recognised |
| rsp_suppress | output | 1 | 1 = suppress, 0 = terminate (meaningful when invalid) |
| rsp_byte_we | output | 16 | Per-byte write enable, bit i for the byte at start address + i |

## Verification
Every result is due exactly one rising edge after its request, and no result depends on any earlier request. The bench drives a request on a falling edge and compares all four outputs on the next falling edge. By then the single result register has loaded, and no new request has yet been accepted. A back-to-back run compares each result in the half-cycle before the following request reaches the register. An idle falling edge after each request confirms that the outputs return to zero.

// File: rtl/saddr_pkg.sv
package saddr_pkg;
  localparam int unsigned DEF_ADDR_W    = 24;
  localparam int unsigned DEF_PAGE_LSB  = 11;
  localparam int unsigned DEF_MAX_BYTES = 16;

  // Outcome of one access, used inside the classifier.
  typedef enum logic [1:0] {
    OUTC_OK   = 2'd0,
    OUTC_TERM = 2'd1,
    OUTC_SUPP = 2'd2
  } outcome_e;
endpackage

// File: rtl/saddr_page_cmp.sv
module saddr_page_cmp #(
  parameter int unsigned PAGE_W = 13,
  localparam int unsigned CAP_W = PAGE_W + 1
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [CAP_W-1:0]  cap,
  output logic              ok
);
  always_comb begin
    ok = ({1'b0, page} < cap);
  end
endmodule

// File: rtl/saddr_lane_map.sv
module saddr_lane_map #(
  parameter int unsigned PAGE_LSB  = 11,
  parameter int unsigned MAX_BYTES = 16,
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PAGE_LSB-1:0]  offs,
  input  logic [LEN_W-1:0]     len_m1,
  output logic [MAX_BYTES-1:0] in_len,
  output logic [MAX_BYTES-1:0] in_next
);
  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
    localparam logic [PAGE_LSB:0] OFS_STEP = (PAGE_LSB+1)'(i);
    localparam logic [LEN_W-1:0]  LANE_IX  = LEN_W'(i);
    logic [PAGE_LSB:0] sum;
    always_comb begin
      sum        = {1'b0, offs} + OFS_STEP;
      in_next[i] = sum[PAGE_LSB];
      in_len[i]  = (LANE_IX <= len_m1);
    end
  end

  // R3
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_len) == (32'(len_m1) + 32'd1));

  // R3
  next_page_suffix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_next << 1) & ~in_next) == '0);
endmodule

// File: rtl/saddr_classify.sv
module saddr_classify
  import saddr_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ifetch,
  input  logic                 store_only,
  input  logic                 always_supp,
  input  logic [MAX_BYTES-1:0] in_len,
  input  logic [MAX_BYTES-1:0] in_next,
  input  logic                 ok_cur,
  input  logic                 ok_nxt,
  output logic                 invalid,
  output logic                 suppress,
  output logic [MAX_BYTES-1:0] byte_we
);
  logic [MAX_BYTES-1:0] byte_ok;
  logic [MAX_BYTES-1:0] bad;
  logic                 all_bad;
  outcome_e             outc;

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_ok
    always_comb byte_ok[i] = in_next[i] ? ok_nxt : ok_cur;
  end

  always_comb begin
    bad     = in_len & ~byte_ok;
    all_bad = (bad == in_len);
    if (bad == '0)
      outc = OUTC_OK;
    else if (ifetch || always_supp || (store_only && all_bad))
      outc = OUTC_SUPP;
    else
      outc = OUTC_TERM;
    invalid  = (outc != OUTC_OK);
    suppress = (outc == OUTC_SUPP);
    if (store_only && !ifetch && (outc != OUTC_SUPP))
      byte_we = in_len & byte_ok;
    else
      byte_we = '0;
  end

  // R5
  supp_needs_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |-> invalid);

  // R8
  we_within_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we & ~in_len) == '0);

  // R9
  we_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we != '0) |-> (store_only && !ifetch && !suppress));
endmodule

// File: rtl/saddr_chk.sv
module saddr_chk
  import saddr_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned PAGE_LSB  = DEF_PAGE_LSB,
  parameter int unsigned MAX_BYTES = DEF_MAX_BYTES,
  localparam int unsigned PAGE_W   = ADDR_W - PAGE_LSB,
  localparam int unsigned CAP_W    = PAGE_W + 1,
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_vld,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_len_m1,
  input  logic                 req_ifetch,
  input  logic                 req_store_only,
  input  logic                 req_always_supp,
  input  logic [CAP_W-1:0]     page_cap,
  output logic                 rsp_vld,
  output logic                 rsp_invalid,
  output logic                 rsp_suppress,
  output logic [MAX_BYTES-1:0] rsp_byte_we
);
  // Reset: asserted at once, released on a clock edge.
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  // Two pages at most: the start page and the one after it.
  logic [PAGE_W-1:0]    page0;
  logic [1:0]           pg_ok;
  logic [MAX_BYTES-1:0] in_len, in_next;

  always_comb page0 = req_addr[ADDR_W-1:PAGE_LSB];

  for (genvar k = 0; k < 2; k++) begin : g_pg
    localparam logic [PAGE_W-1:0] STEP = PAGE_W'(k);
    saddr_page_cmp #(.PAGE_W(PAGE_W)) u_cmp (
      .page (page0 + STEP),
      .cap  (page_cap),
      .ok   (pg_ok[k])
    );
  end

  saddr_lane_map #(.PAGE_LSB(PAGE_LSB), .MAX_BYTES(MAX_BYTES)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .offs    (req_addr[PAGE_LSB-1:0]),
    .len_m1  (req_len_m1),
    .in_len  (in_len),
    .in_next (in_next)
  );

  logic                 c_invalid, c_suppress;
  logic [MAX_BYTES-1:0] c_we;

  saddr_classify #(.MAX_BYTES(MAX_BYTES)) u_cls (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .ifetch      (req_ifetch),
    .store_only  (req_store_only),
    .always_supp (req_always_supp),
    .in_len      (in_len),
    .in_next     (in_next),
    .ok_cur      (pg_ok[0]),
    .ok_nxt      (pg_ok[1]),
    .invalid     (c_invalid),
    .suppress    (c_suppress),
    .byte_we     (c_we)
  );

  // Next-state logic
  logic                 vld_d, inv_d, sup_d;
  logic [MAX_BYTES-1:0] we_d;
  always_comb begin
    vld_d = req_vld;
    inv_d = req_vld & c_invalid;
    sup_d = req_vld & c_suppress;
    we_d  = req_vld ? c_we : '0;
  end

  // Result register
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_vld      <= 1'b0;
      rsp_invalid  <= 1'b0;
      rsp_suppress <= 1'b0;
      rsp_byte_we  <= '0;
    end else begin
      rsp_vld      <= vld_d;
      rsp_invalid  <= inv_d;
      rsp_suppress <= sup_d;
      rsp_byte_we  <= we_d;
    end
  end

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_vld |=> rsp_vld);

  // R1
  idle_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_vld |=> (!rsp_vld && !rsp_invalid && !rsp_suppress && rsp_byte_we == '0));

  // R4
  ifetch_suppresses_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && req_ifetch) |=> (!rsp_invalid || (rsp_suppress && rsp_byte_we == '0)));

  // R6
  always_supp_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && req_always_supp) |=> (!rsp_invalid || (rsp_suppress && rsp_byte_we == '0)));
endmodule

// File: tb/saddr_chk_tb.sv
module saddr_chk_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld;
  logic [23:0] req_addr;
  logic [3:0]  req_len_m1;
  logic        req_ifetch, req_store_only, req_always_supp;
  logic [13:0] page_cap;
  logic        rsp_vld, rsp_invalid, rsp_suppress;
  logic [15:0] rsp_byte_we;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  saddr_chk u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
    .req_len_m1(req_len_m1), .req_ifetch(req_ifetch),
    .req_store_only(req_store_only), .req_always_supp(req_always_supp),
    .page_cap(page_cap), .rsp_vld(rsp_vld), .rsp_invalid(rsp_invalid),
    .rsp_suppress(rsp_suppress), .rsp_byte_we(rsp_byte_we)
  );

  typedef struct packed {
    logic        f;    // ifetch
    logic        s;    // store-only
    logic        a;    // always-suppress class
    logic [3:0]  l;    // length minus one
    logic [23:0] ad;
    logic [13:0] cap;
    logic        inv;
    logic        sup;
    logic [15:0] we;
    logic [7:0]  rq;   // requirement number for messages
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,4'd3, 24'h001000,14'd16,  1'b0,1'b0,16'h0000,8'd9}, // R9 read valid
    '{1'b0,1'b1,1'b0,4'd7, 24'h000100,14'd16,  1'b0,1'b0,16'h00FF,8'd8}, // R8 full store
    '{1'b0,1'b1,1'b0,4'd15,24'h007FF8,14'd16,  1'b1,1'b0,16'h00FF,8'd8}, // R8 partial store
    '{1'b0,1'b1,1'b0,4'd3, 24'h008000,14'd16,  1'b1,1'b1,16'h0000,8'd7}, // R7 all bad store
    '{1'b0,1'b0,1'b0,4'd1, 24'h008000,14'd16,  1'b1,1'b0,16'h0000,8'd5}, // R5 read bad
    '{1'b0,1'b0,1'b0,4'd3, 24'h007FFE,14'd16,  1'b1,1'b0,16'h0000,8'd3}, // R3 read crossing
    '{1'b0,1'b0,1'b1,4'd3, 24'h00FFF0,14'd16,  1'b1,1'b1,16'h0000,8'd6}, // R6 class bad
    '{1'b0,1'b0,1'b1,4'd3, 24'h000000,14'd16,  1'b0,1'b0,16'h0000,8'd6}, // R6 class ok
    '{1'b1,1'b0,1'b0,4'd5, 24'h009000,14'd16,  1'b1,1'b1,16'h0000,8'd4}, // R4 fetch bad
    '{1'b1,1'b0,1'b0,4'd5, 24'h007FFC,14'd16,  1'b1,1'b1,16'h0000,8'd4}, // R4 last halfword
    '{1'b1,1'b0,1'b0,4'd1, 24'h007FFE,14'd16,  1'b0,1'b0,16'h0000,8'd4}, // R4 fetch ok
    '{1'b0,1'b0,1'b0,4'd1, 24'h008000,14'd17,  1'b0,1'b0,16'h0000,8'd2}, // R2 below count
    '{1'b0,1'b0,1'b0,4'd0, 24'h007FFF,14'd15,  1'b1,1'b0,16'h0000,8'd2}, // R2 equal count
    '{1'b0,1'b1,1'b0,4'd7, 24'hFFFFFC,14'd16,  1'b1,1'b0,16'h00F0,8'd3}, // R3 wrap
    '{1'b0,1'b1,1'b0,4'd15,24'hFFFFF0,14'd8192,1'b0,1'b0,16'hFFFF,8'd2}, // R2 full count
    '{1'b0,1'b0,1'b0,4'd0, 24'h000000,14'd0,   1'b1,1'b0,16'h0000,8'd2}, // R2 zero count
    '{1'b0,1'b1,1'b1,4'd15,24'h007FF8,14'd16,  1'b1,1'b1,16'h0000,8'd6}, // R6 partial store
    '{1'b0,1'b1,1'b0,4'd0, 24'h007FFF,14'd16,  1'b0,1'b0,16'h0001,8'd8}, // R8 one byte
    '{1'b1,1'b1,1'b0,4'd3, 24'h000040,14'd16,  1'b0,1'b0,16'h0000,8'd4}  // R4 fetch no write
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_vld         = 1'b1;
    req_ifetch      = v.f;
    req_store_only  = v.s;
    req_always_supp = v.a;
    req_len_m1      = v.l;
    req_addr        = v.ad;
    page_cap        = v.cap;
  endtask

  task automatic chk_vec(input vec_t v, input int idx);
    string t;
    t = $sformatf("R%0d vec%0d", v.rq, idx);
    chk({t, " vld"}, 32'(rsp_vld), 32'd1);
    chk({t, " inv"}, 32'(rsp_invalid), 32'(v.inv));
    chk({t, " sup"}, 32'(rsp_suppress), 32'(v.sup));
    chk({t, " we"},  32'(rsp_byte_we), 32'(v.we));
  endtask

  task automatic chk_zero(input string tag);
    chk({tag, " vld"}, 32'(rsp_vld), 32'd0);
    chk({tag, " inv"}, 32'(rsp_invalid), 32'd0);
    chk({tag, " sup"}, 32'(rsp_suppress), 32'd0);
    chk({tag, " we"},  32'(rsp_byte_we), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; req_addr = '0; req_len_m1 = '0;
    req_ifetch = 1'b0; req_store_only = 1'b0; req_always_supp = 1'b0;
    page_cap = 14'd16;
    repeat (3) @(negedge clk);
    chk_zero("R10 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_zero("R10 after release");

    // Table walk: drive on a falling edge, compare one edge later, then idle.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      req_vld = 1'b0;
      chk_vec(VEC[i], i);
      @(negedge clk);
      chk_zero("R1 idle");
    end

    // Back-to-back requests: each result belongs only to its own request (R1).
    @(negedge clk);
    drive(VEC[3]);
    @(negedge clk);
    chk_vec(VEC[3], 3);
    drive(VEC[1]);
    @(negedge clk);
    chk_vec(VEC[1], 1);
    drive(VEC[8]);
    @(negedge clk);
    chk_vec(VEC[8], 8);
    req_vld = 1'b0;
    @(negedge clk);
    chk_zero("R1 after burst");

    // Reset in the middle of a request stream clears the result (R10).
    drive(VEC[2]);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_zero("R10 async clear");
    req_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_zero("R10 idle after reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule